// File: doc/BRIEF.md
# Dual-Edge Multichannel PWM Timer

This block produces six pulse-width modulated outputs from one shared timebase. A prescale counter divides the clock. Each time the prescaler wraps, a timer count advances by one. Seven match values are compared against the timer count on every such tick. Any match can be programmed to return the count to zero, to halt the timebase, and to latch an interrupt flag. Match 0 with its return-to-zero action enabled sets the PWM period.

Each output channel n, from 1 to 6, is driven low by match n. In single-edge mode the channel goes high at the start of each period. In dual-edge mode it goes high on match n-1 instead, so two neighbouring match values give the channel a rising and a falling edge that are placed independently. Each channel has an output enable. Match values written over the register bus land in a shadow copy. The comparators pick up a shadow value only when its load bit is armed, at the next period boundary.

The block is configured over a small word-addressed register bus with single-cycle writes and a combinational read path. Interrupt flags are cleared by writing a 1 to them.

Top module: `pwm_dual_edge`

## Requirements
- R1: After reset every register reads 0, all PWM outputs are low and the interrupt line is low.
- R2: While running (control bit 0 at address 0 set), the timer count at address 6 advances by one once every PRESCALE+1 clock cycles, where PRESCALE is the value at address 1.
- R3: When match 0 has its return-to-zero action set, the timer count cycles through 0 to M0 and wraps from M0 to 0. The action field at address 2 gives 3 bits per match m at bits [3m+2:3m], in the order irq, return-to-zero, halt from the low bit up.
- R4: A channel in single-edge mode goes high on the tick where the count wraps from M0 and goes low on the tick where the count equals its own match value. When the two coincide the channel stays low, and a match value above M0 leaves it permanently high.
- R5: A channel n in dual-edge mode (bit 8+n-1 at address 3) goes high on match n-1 and low on match n. With equal values it stays low, and a falling match beyond the period leaves it high.
- R6: A channel whose enable (bit n-1 at address 3) is clear drives 0, and its internal state keeps running. Re-enabling shows the current phase at once.
- R7: Writes to the match registers (addresses 8 to 14) read back at once but take effect only at a period boundary with the matching bit at address 4 set. All load bits clear at that boundary.
- R8: A match with its halt action set clears the run bit. The timer count then holds the match value (or 0 if return-to-zero is also set), and the prescaler holds 0.
- R9: A match with its irq action set latches a flag at address 5: matches 0 to 3 at bits 0 to 3, and matches 4 to 6 at bits 8 to 10. The interrupt output is high while any flag is set.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. Bits 4 to 7 always read 0 and ignore writes.
- R11: A match whose irq action is clear sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 6 | PWM outputs, bit n-1 is channel n |
| irq_o | output | 1 | Interrupt, high while any flag is set |

## Verification
The bench builds the block with an 8-bit counter width. With that width, short periods of six and eight ticks and prescale values of 0 to 2 cover the full cycle of the count in a few dozen clocks. The bench sweeps every rising/falling match pair inside a six-tick period for the dual-edge channel, and every single-edge falling point from 0 to beyond an eight-tick period. It compares each sampled output against an arithmetic window computed from the count that it reads back. Halt, shadow loading and flag placement are driven through the same register bus.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_MATCH = 7;
  localparam int NUM_CH    = 6;
  localparam int FLAG_W    = 11;
  localparam int ACT_W     = 3;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_PRESC = 4'd1;
  localparam logic [3:0] A_MACT  = 4'd2;
  localparam logic [3:0] A_OUTC  = 4'd3;
  localparam logic [3:0] A_LDEN  = 4'd4;
  localparam logic [3:0] A_FLAG  = 4'd5;
  localparam logic [3:0] A_TC    = 4'd6;
  localparam logic [3:0] A_PC    = 4'd7;
  localparam logic [3:0] A_MR0   = 4'd8;

  localparam logic [FLAG_W-1:0] FLAG_MASK = 11'h70F;

  // per-match action, irq in the low bit
  typedef struct packed {
    logic halt;
    logic zero;
    logic irq;
  } mact_t;

  function automatic int flag_pos(int m);
    return (m < 4) ? m : m + 4;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] presc_i,
  input  logic             zero_hit_i,
  input  logic             halt_hit_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] tc_o,
  output logic [CNT_W-1:0] pc_o
);
  logic [CNT_W-1:0] pc_q, tc_q;

  // >= keeps the prescaler bounded if the limit is lowered mid-count
  assign tick_o = run_i && (pc_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (tick_o) begin
      pc_q <= '0;
      if (zero_hit_i)      tc_q <= '0;
      else if (!halt_hit_i) tc_q <= tc_q + 1'b1;
    end else if (run_i) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign tc_o = tc_q;
  assign pc_o = pc_q;
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int CNT_W = 16,
  parameter int N     = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              wr_en_i,
  input  logic [CNT_W-1:0]          wdata_i,
  input  logic                      tick_i,
  input  logic [CNT_W-1:0]          tc_i,
  input  logic                      load_i,
  input  logic [N-1:0]              lden_i,
  output logic [N-1:0][CNT_W-1:0]   shadow_o,
  output logic [N-1:0]              hit_o
);
  for (genvar m = 0; m < N; m++) begin : g_match
    logic [CNT_W-1:0] shadow_q, active_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_en_i[m])            shadow_q <= wdata_i;
        if (load_i && lden_i[m])   active_q <= shadow_q;
      end
    end

    assign hit_o[m]    = tick_i && (tc_i == active_q);
    assign shadow_o[m] = shadow_q;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbl_i,
  input  logic en_i,
  input  logic set_period_i,
  input  logic set_prev_i,
  input  logic clr_i,
  output logic pwm_o
);
  logic state_q;
  logic set;

  assign set = dbl_i ? set_prev_i : set_period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= 1'b0;
    else if (clr_i)  state_q <= 1'b0;  // falling edge wins a tie
    else if (set)    state_q <= 1'b1;
  end

  assign pwm_o = state_q & en_i;
endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge #(
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [5:0]  pwm_o,
  output logic        irq_o
);
  import pwm_pkg::*;

  localparam int MACT_W = NUM_MATCH * ACT_W;

  logic                   run_q;
  logic [CNT_W-1:0]       presc_q;
  mact_t [NUM_MATCH-1:0]  mact_q;
  logic [NUM_CH-1:0]      en_q, dbl_q;
  logic [NUM_MATCH-1:0]   lden_q;
  logic [FLAG_W-1:0]      flag_q;

  logic                   tick;
  logic [CNT_W-1:0]       tc, pc;
  logic [NUM_MATCH-1:0]   hit, mr_wr;
  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow;
  logic                   boundary, zero_any, halt_any;
  logic [FLAG_W-1:0]      flag_set, flag_clr;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata_i[31:MACT_W];

  always_comb begin
    zero_any = 1'b0;
    halt_any = 1'b0;
    for (int m = 0; m < NUM_MATCH; m++) begin
      zero_any |= hit[m] & mact_q[m].zero;
      halt_any |= hit[m] & mact_q[m].halt;
      mr_wr[m]  = we_i && (addr_i == 4'(A_MR0 + m));
    end
  end

  assign boundary = hit[0] & mact_q[0].zero;

  pwm_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .presc_i    (presc_q),
    .zero_hit_i (zero_any),
    .halt_hit_i (halt_any),
    .tick_o     (tick),
    .tc_o       (tc),
    .pc_o       (pc)
  );

  pwm_match_bank #(.CNT_W(CNT_W), .N(NUM_MATCH)) i_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (mr_wr),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .tick_i   (tick),
    .tc_i     (tc),
    .load_i   (boundary),
    .lden_i   (lden_q),
    .shadow_o (shadow),
    .hit_o    (hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan i_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .dbl_i        (dbl_q[c]),
      .en_i         (en_q[c]),
      .set_period_i (boundary),
      .set_prev_i   (hit[c]),
      .clr_i        (hit[c+1]),
      .pwm_o        (pwm_o[c])
    );
  end

  always_comb begin
    flag_set = '0;
    for (int m = 0; m < NUM_MATCH; m++)
      flag_set[flag_pos(m)] = hit[m] & mact_q[m].irq;
    flag_clr = (we_i && addr_i == A_FLAG) ? wdata_i[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      presc_q <= '0;
      mact_q  <= '0;
      en_q    <= '0;
      dbl_q   <= '0;
      lden_q  <= '0;
      flag_q  <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) run_q <= wdata_i[0];
      else if (halt_any)            run_q <= 1'b0;

      if (we_i && addr_i == A_PRESC) presc_q <= wdata_i[CNT_W-1:0];
      if (we_i && addr_i == A_MACT)  mact_q  <= wdata_i[MACT_W-1:0];
      if (we_i && addr_i == A_OUTC) begin
        en_q  <= wdata_i[NUM_CH-1:0];
        dbl_q <= wdata_i[8+NUM_CH-1:8];
      end

      if (we_i && addr_i == A_LDEN) lden_q <= wdata_i[NUM_MATCH-1:0];
      else if (boundary)            lden_q <= '0;

      flag_q <= ((flag_q & ~flag_clr) | flag_set) & FLAG_MASK;
    end
  end

  assign irq_o = |flag_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = 32'(run_q);
      A_PRESC: rdata_o = 32'(presc_q);
      A_MACT:  rdata_o = 32'(mact_q);
      A_OUTC:  rdata_o = 32'({dbl_q, 2'b00, en_q});
      A_LDEN:  rdata_o = 32'(lden_q);
      A_FLAG:  rdata_o = 32'(flag_q);
      A_TC:    rdata_o = 32'(tc);
      A_PC:    rdata_o = 32'(pc);
      default: begin
        for (int m = 0; m < NUM_MATCH; m++)
          if (addr_i == 4'(A_MR0 + m)) rdata_o = 32'(shadow[m]);
      end
    endcase
  end
endmodule

// File: rtl/pwm_dual_edge_chk.sv
module pwm_dual_edge_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [3:0]       addr_i,
  input logic             run_q,
  input logic [CNT_W-1:0] tc,
  input logic             boundary,
  input logic             halt_any,
  input logic [6:0]       hit,
  input logic [20:0]      mact_q,
  input logic [10:0]      flag_q,
  input logic [5:0]       pwm_o
);
  import pwm_pkg::*;

  a_r8_halt_stops_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_any && !(we_i && addr_i == A_CTRL)) |=> !run_q);

  a_r8_idle_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> $stable(tc));

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary |=> (tc == '0));

  for (genvar c = 0; c < 6; c++) begin : g_clr
    a_r5_match_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[c+1] |=> !pwm_o[c]);
  end

  for (genvar m = 0; m < 7; m++) begin : g_flag
    a_r9_flag_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[m] && mact_q[3*m]) |=> flag_q[flag_pos(m)]);
  end
endmodule

bind pwm_dual_edge pwm_dual_edge_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .run_q    (run_q),
  .tc       (tc),
  .boundary (boundary),
  .halt_any (halt_any),
  .hit      (hit),
  .mact_q   (mact_q),
  .flag_q   (flag_q),
  .pwm_o    (pwm_o)
);

// File: tb/test_pwm_dual_edge.sv
`timescale 1ns/1ps
module test_pwm_dual_edge;
  localparam int CNT_W = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  pwm_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_dual_edge #(.CNT_W(CNT_W)) i_pwm_dual_edge (.*);

  task automatic chk(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, int d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic sample(output int t, output logic [5:0] o);
    @(negedge clk_i);
    addr_i = 4'd6;
    #1 t = rdata_o; o = pwm_o;
  endtask

  // window where a channel is high: rises after tick a, falls after tick b
  function automatic bit exp_out(int t, int p, int a, int b);
    int s, c;
    if (a >= p) return 1'b0;
    if (b >= p) return 1'b1;
    if (a == b) return 1'b0;
    s = (a + 1) % p;
    c = (b + 1) % p;
    if (s < c) return (t >= s) && (t < c);
    return (t >= s) || (t < c);
  endfunction

  task automatic win_check(string req, int bit_i, int p, int a, int b, int n);
    int t, bad, lt;
    logic [5:0] o;
    bad = 0; lt = 0;
    for (int i = 0; i < n; i++) begin
      sample(t, o);
      if (o[bit_i] != exp_out(t, p, a, b)) begin bad++; lt = t; end
    end
    chk(req, bad == 0, bad, 0);
    if (bad != 0) $display("  mismatch window a=%0d b=%0d last tc=%0d", a, b, lt);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d, t, prev, bad, cur;
    logic [5:0] o;

    // R1 reset values
    do_reset();
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), d);
      chk("R1", d == 0, d, 0);
    end
    chk("R1", pwm_o == 0, int'(pwm_o), 0);
    chk("R1", irq_o == 0, int'(irq_o), 0);

    // R2 prescale spacing
    do_reset();
    wr(4'd1, 2); wr(4'd8, 200); wr(4'd4, 1); wr(4'd2, 2); wr(4'd0, 1);
    t = 0;
    for (int i = 0; i < 100 && t != 3; i++) sample(t, o);
    chk("R2", t == 3, t, 3);
    cur = 3;
    for (int j = 0; j < 6; j++) begin
      sample(t, o); chk("R2", t == cur, t, cur);
      sample(t, o); chk("R2", t == cur, t, cur);
      sample(t, o); chk("R2", t == cur + 1, t, cur + 1);
      cur++;
    end

    // R3 period wrap
    do_reset();
    wr(4'd8, 5); wr(4'd2, 2); wr(4'd4, 1); wr(4'd0, 1);
    repeat (10) @(negedge clk_i);
    sample(prev, o);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      sample(t, o);
      if (t != (prev + 1) % 6 || t > 5) bad++;
      prev = t;
    end
    chk("R3", bad == 0, bad, 0);

    // R4 single-edge sweep, period 8 ticks, prescale 1, channel 3
    do_reset();
    wr(4'd1, 1); wr(4'd8, 7); wr(4'd2, 2); wr(4'd3, 32'h04);
    for (int k = 0; k < 10; k++) begin
      wr(4'd11, k); wr(4'd4, 32'h09);
      if (k == 0) wr(4'd0, 1);
      repeat (48) @(negedge clk_i);
      win_check("R4", 2, 8, 7, k, 32);
    end

    // R5 dual-edge sweep, period 6 ticks, channel 2
    do_reset();
    wr(4'd8, 5); wr(4'd2, 2); wr(4'd3, 32'h202);
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        wr(4'd9, a); wr(4'd10, b); wr(4'd4, 32'h07);
        if (a == 0 && b == 0) wr(4'd0, 1);
        repeat (20) @(negedge clk_i);
        win_check("R5", 1, 6, a, b, 12);
      end
    end
    wr(4'd9, 2); wr(4'd10, 7); wr(4'd4, 32'h06);
    repeat (20) @(negedge clk_i);
    win_check("R5", 1, 6, 2, 7, 12);

    // R6 enable gating keeps phase
    wr(4'd9, 1); wr(4'd10, 4); wr(4'd4, 32'h06);
    repeat (20) @(negedge clk_i);
    wr(4'd3, 32'h200);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      sample(t, o);
      if (o[1] != 1'b0) bad++;
    end
    chk("R6", bad == 0, bad, 0);
    wr(4'd3, 32'h202);
    win_check("R6", 1, 6, 1, 4, 12);

    // R7 shadow load
    wr(4'd10, 2);
    rd(4'd10, d); chk("R7", d == 2, d, 2);
    repeat (20) @(negedge clk_i);
    win_check("R7", 1, 6, 1, 4, 12);
    wr(4'd4, 32'h04);
    repeat (20) @(negedge clk_i);
    win_check("R7", 1, 6, 1, 2, 12);
    rd(4'd4, d); chk("R7", d == 0, d, 0);

    // R8 halt action
    do_reset();
    wr(4'd8, 50); wr(4'd11, 9); wr(4'd4, 32'h09); wr(4'd2, 2); wr(4'd0, 1);
    wr(4'd2, 2 | (1 << 11));
    repeat (30) @(negedge clk_i);
    rd(4'd0, d); chk("R8", d == 0, d, 0);
    rd(4'd6, d); chk("R8", d == 9, d, 9);
    repeat (5) @(negedge clk_i);
    rd(4'd6, d); chk("R8", d == 9, d, 9);
    rd(4'd7, d); chk("R8", d == 0, d, 0);

    // R11, R9, R10 flags
    do_reset();
    wr(4'd8, 7);
    for (int m = 1; m < 7; m++) wr(4'(8 + m), m);
    wr(4'd4, 32'h7F);
    wr(4'd2, 2 | (1 << 6));
    wr(4'd0, 1);
    repeat (20) @(negedge clk_i);
    rd(4'd5, d); chk("R11", d == 32'h004, d, 32'h004);
    chk("R9", irq_o == 1'b1, int'(irq_o), 1);
    wr(4'd2, 32'h4924B);
    repeat (20) @(negedge clk_i);
    rd(4'd5, d); chk("R9", d == 32'h70F, d, 32'h70F);
    wr(4'd2, 2);
    wr(4'd5, 32'h0F0);
    rd(4'd5, d); chk("R10", d == 32'h70F, d, 32'h70F);
    wr(4'd5, 0);
    rd(4'd5, d); chk("R10", d == 32'h70F, d, 32'h70F);
    wr(4'd5, 32'h100);
    rd(4'd5, d); chk("R10", d == 32'h60F, d, 32'h60F);
    wr(4'd5, 32'h60F);
    rd(4'd5, d); chk("R10", d == 0, d, 0);
    chk("R10", irq_o == 1'b0, int'(irq_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule